// File: doc/BRIEF.md
# Processor Power Mode Controller

This block holds the processor's power-management control word and turns it into the low-power controls of the core. Software writes the word to select a clock slow-down setting and to request a doze or a sleep state. The block passes the slow-down setting straight out to an external clock divider. From the two mode requests it drives one clock enable per internal processor unit, separate clock enables for the tick timer and the interrupt controller, and a request to lower the supply voltage.

Doze and sleep are entered by software and left by hardware. When the interrupt controller signals a pending interrupt, the block clears both mode requests in its register on that clock edge. On the following edge it turns every clock enable back on and drops the voltage request. The clock generator and the voltage regulator are outside this block.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the control word reads zero, every unit clock enable and the timer and interrupt-controller enables are 1, and `vdd_low_req` is 0.
- R2: A write (`wr_en`=1, `irq_pending`=0) updates the control word on that edge. `rd_data` then shows bits 5:0 of the written value, and bits 31:6 always read zero.
- R3: The slow-down factor is bits 3:0 of the control word, where a lower value means higher performance. `slow_factor` equals that field and has no effect on any enable or on `vdd_low_req`.
- R4: When bit 4 (doze) is set and bit 5 (sleep) is clear, one edge after the register changes, all `unit_clk_en` bits are 0, `timer_clk_en` and `intc_clk_en` stay 1, and `vdd_low_req` is 0.
- R5: When bit 5 (sleep) is set, one edge after the register changes, all unit enables, `timer_clk_en` and `intc_clk_en` are 0, and `vdd_low_req` is 1.
- R6: When bits 4 and 5 are both set, the outputs match the sleep state of R5.
- R7: `irq_pending`=1 on an edge clears bits 4 and 5 of the control word on that edge and leaves bits 3:0 unchanged.
- R8: One edge after the mode bits are cleared, every clock enable is 1 again and `vdd_low_req` is 0.
- R9: A write on an edge where `irq_pending`=1 takes bits 3:0 from the written value and leaves bits 4 and 5 at zero.
- R10: `irq_pending` in normal operation changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Value to write |
| irq_pending | input | 1 | Interrupt pending from the interrupt controller |
| rd_data | output | 32 | Current control word, reserved bits zero |
| slow_factor | output | 4 | Slow-down factor for the external clock divider |
| unit_clk_en | output | NUM_UNITS (8) | Clock enable per gated internal unit |
| timer_clk_en | output | 1 | Tick timer clock enable |
| intc_clk_en | output | 1 | Interrupt controller clock enable |
| vdd_low_req | output | 1 | Request to lower the core supply |

## Verification
Directed sequences cover doze alone, sleep alone, both requests together, an interrupt arriving in each low-power state, a write that meets an interrupt on the same edge, and an interrupt in normal operation. Together they show whether sleep wins over doze, whether the timer and interrupt controller are kept apart from the gated units, and whether the one-edge gap between clearing a bit and restoring the enables is kept. Random writes with random interrupt timing then mix the slow-down values with the mode bits and written reserved bits. This shows whether the slow-down field leaks into the enables and whether a reserved bit ever reads back as one.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    localparam int SDF_W     = 4;
    localparam int SDF_LSB   = 0;
    localparam int DOZE_BIT  = SDF_LSB + SDF_W;
    localparam int SLEEP_BIT = DOZE_BIT + 1;
    localparam int USED_W    = SLEEP_BIT + 1;

    typedef enum logic [1:0] {
        PM_RUN   = 2'd0,
        PM_DOZE  = 2'd1,
        PM_SLEEP = 2'd2
    } pm_state_e;

    typedef struct packed {
        logic             sleep;
        logic             doze;
        logic [SDF_W-1:0] sdf;
    } pm_word_t;
endpackage

// File: rtl/pmc_word_reg.sv
module pmc_word_reg
    import pmc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [USED_W-1:0] wr_bits,
    input  logic              irq_pending,
    output pm_word_t          word_o
);
    typedef struct packed {
        pm_word_t word;
    } reg_state_t;

    reg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.word.sdf   = wr_bits[SDF_LSB +: SDF_W];
            s_d.word.doze  = wr_bits[DOZE_BIT];
            s_d.word.sleep = wr_bits[SLEEP_BIT];
        end
        // A pending interrupt always wins over a software mode request.
        if (irq_pending) begin
            s_d.word.doze  = 1'b0;
            s_d.word.sleep = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_o = s_q.word;
endmodule

// File: rtl/pmc_mode_fsm.sv
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pm_word_t  word_i,
    output pm_state_e state_o
);
    typedef struct packed {
        pm_state_e state;
    } fsm_state_t;

    fsm_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (word_i.sleep)     s_d.state = PM_SLEEP;   // sleep has precedence
        else if (word_i.doze) s_d.state = PM_DOZE;
        else                  s_d.state = PM_RUN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: PM_RUN};
        else        s_q <= s_d;
    end

    assign state_o = s_q.state;
endmodule

// File: rtl/pmc_enable_drv.sv
module pmc_enable_drv
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS = 8
) (
    input  pm_state_e            state_i,
    output logic [NUM_UNITS-1:0] unit_en_o,
    output logic                 timer_en_o,
    output logic                 intc_en_o,
    output logic                 vdd_low_o
);
    logic run_c;
    logic awake_c;

    always_comb begin
        run_c   = (state_i == PM_RUN);
        awake_c = (state_i != PM_SLEEP);
    end

    for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
        assign unit_en_o[g] = run_c;
    end

    assign timer_en_o = awake_c;
    assign intc_en_o  = awake_c;
    assign vdd_low_o  = !awake_c;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int REG_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 irq_pending,
    output logic [REG_W-1:0]     rd_data,
    output logic [SDF_W-1:0]     slow_factor,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 timer_clk_en,
    output logic                 intc_clk_en,
    output logic                 vdd_low_req
);
    pm_word_t  word;
    pm_state_e state;
    logic      unused_rsvd;

    assign unused_rsvd = ^wr_data[REG_W-1:USED_W];

    pmc_word_reg i_word (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_bits     (wr_data[USED_W-1:0]),
        .irq_pending (irq_pending),
        .word_o      (word)
    );

    pmc_mode_fsm i_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_i  (word),
        .state_o (state)
    );

    pmc_enable_drv #(.NUM_UNITS(NUM_UNITS)) i_drv (
        .state_i    (state),
        .unit_en_o  (unit_clk_en),
        .timer_en_o (timer_clk_en),
        .intc_en_o  (intc_clk_en),
        .vdd_low_o  (vdd_low_req)
    );

    always_comb begin
        rd_data                    = '0;
        rd_data[SDF_LSB +: SDF_W]  = word.sdf;
        rd_data[DOZE_BIT]          = word.doze;
        rd_data[SLEEP_BIT]         = word.sleep;
    end

    assign slow_factor = word.sdf;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker
    import pmc_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int REG_W     = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en,
    input logic [REG_W-1:0]     wr_data,
    input logic                 irq_pending,
    input logic [REG_W-1:0]     rd_data,
    input logic [SDF_W-1:0]     slow_factor,
    input logic [NUM_UNITS-1:0] unit_clk_en,
    input logic                 timer_clk_en,
    input logic                 intc_clk_en,
    input logic                 vdd_low_req
);
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !irq_pending) |=> (rd_data[USED_W-1:0] == $past(wr_data[USED_W-1:0])));

    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:USED_W] == '0);

    a_r3_factor_out: assert property (@(posedge clk) disable iff (!rst_n)
        slow_factor == rd_data[SDF_LSB +: SDF_W]);

    a_r4_doze_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[DOZE_BIT] && !rd_data[SLEEP_BIT]) |=>
        (unit_clk_en == '0 && timer_clk_en && intc_clk_en && !vdd_low_req));

    a_r5_sleep_off: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SLEEP_BIT] |=>
        (unit_clk_en == '0 && !timer_clk_en && !intc_clk_en && vdd_low_req));

    a_r7_irq_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |=> (!rd_data[DOZE_BIT] && !rd_data[SLEEP_BIT]));

    a_r7_irq_keeps_factor: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pending && !wr_en) |=> $stable(slow_factor));

    a_r8_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[DOZE_BIT] && !rd_data[SLEEP_BIT]) |=>
        (&unit_clk_en && timer_clk_en && intc_clk_en && !vdd_low_req));
endmodule

bind pwr_mode_ctrl pmc_checker #(.NUM_UNITS(NUM_UNITS), .REG_W(REG_W)) i_pmc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .irq_pending  (irq_pending),
    .rd_data      (rd_data),
    .slow_factor  (slow_factor),
    .unit_clk_en  (unit_clk_en),
    .timer_clk_en (timer_clk_en),
    .intc_clk_en  (intc_clk_en),
    .vdd_low_req  (vdd_low_req)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int NU = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          irq_pending = 1'b0;
    logic [31:0]   rd_data;
    logic [3:0]    slow_factor;
    logic [NU-1:0] unit_clk_en;
    logic          timer_clk_en, intc_clk_en, vdd_low_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [5:0] m_word  = '0;  // model control word bits 5:0
    logic [1:0] m_state = '0;  // 0 run, 1 doze, 2 sleep

    always #4 clk = ~clk;

    pwr_mode_ctrl #(.NUM_UNITS(NU)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pending(irq_pending), .rd_data(rd_data), .slow_factor(slow_factor),
        .unit_clk_en(unit_clk_en), .timer_clk_en(timer_clk_en),
        .intc_clk_en(intc_clk_en), .vdd_low_req(vdd_low_req)
    );

    function automatic logic [1:0] mode_of(input logic [5:0] w);
        if (w[5])      return 2'd2;
        else if (w[4]) return 2'd1;
        else           return 2'd0;
    endfunction

    function automatic logic [5:0] next_word(input logic [5:0] w, input logic we,
                                             input logic [31:0] d, input logic irq);
        logic [5:0] n = w;
        if (we) n = d[5:0];
        if (irq) n[5:4] = 2'b00;
        return n;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check({tag, " R2 rd_data"}, rd_data, {26'd0, m_word});
        check({tag, " R3 slow_factor"}, {28'd0, slow_factor}, {28'd0, m_word[3:0]});
        check({tag, " R4 R5 R8 unit_clk_en"}, {24'd0, unit_clk_en},
              {24'd0, (m_state == 2'd0) ? {NU{1'b1}} : {NU{1'b0}}});
        check({tag, " R4 R5 R8 timer_clk_en"}, {31'd0, timer_clk_en}, {31'd0, m_state != 2'd2});
        check({tag, " R4 R5 R8 intc_clk_en"}, {31'd0, intc_clk_en}, {31'd0, m_state != 2'd2});
        check({tag, " R5 R6 vdd_low_req"}, {31'd0, vdd_low_req}, {31'd0, m_state == 2'd2});
    endtask

    task automatic step(input string tag, input logic we, input logic [31:0] d, input logic irq);
        @(negedge clk);
        wr_en = we; wr_data = d; irq_pending = irq;
        @(posedge clk);
        m_state = mode_of(m_word);
        m_word  = next_word(m_word, we, d, irq);
        #2;
        check_all(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #1;
        check_all("R1 reset");
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1 after release");

        // R2 R3: factor with reserved bits set in the write
        step("R2 R3 write factor", 1'b1, 32'hFFFF_FFCA, 1'b0);
        step("R3 factor steady", 1'b0, '0, 1'b0);
        // R4: doze alone
        step("R4 enter doze", 1'b1, 32'h0000_0013, 1'b0);
        step("R4 doze settled", 1'b0, '0, 1'b0);
        step("R4 doze hold", 1'b0, '0, 1'b0);
        // R7 R8: interrupt wakes from doze
        step("R7 irq in doze", 1'b0, '0, 1'b1);
        step("R8 enables back", 1'b0, '0, 1'b0);
        // R5: sleep alone
        step("R5 enter sleep", 1'b1, 32'h0000_0025, 1'b0);
        step("R5 sleep settled", 1'b0, '0, 1'b0);
        step("R7 irq in sleep", 1'b0, '0, 1'b1);
        step("R8 wake from sleep", 1'b0, '0, 1'b0);
        // R6: both set
        step("R6 both bits", 1'b1, 32'h0000_0030, 1'b0);
        step("R6 sleep wins", 1'b0, '0, 1'b0);
        step("R7 R8 irq both", 1'b0, '0, 1'b1);
        step("R8 restored", 1'b0, '0, 1'b0);
        // R9: write meets interrupt
        step("R9 write with irq", 1'b1, 32'h0000_003F, 1'b1);
        step("R9 still run", 1'b0, '0, 1'b0);
        // R10: interrupt in normal operation
        step("R10 irq in run", 1'b0, '0, 1'b1);
        step("R10 irq in run 2", 1'b0, '0, 1'b1);
        step("R10 after", 1'b0, '0, 1'b0);

        for (int i = 0; i < 400; i++) begin
            logic we  = ($urandom_range(2) == 0);
            logic irq = ($urandom_range(4) == 0);
            step("R2 R7 R9 random", we, $urandom, irq);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule